// File: doc/BRIEF.md
# Receive Frame Length Counter

This block sits beside a B-channel receiver running in transparent mode. It counts each byte the receiver accepts. When the receiver signals end of message, it freezes the frame length and an overflow flag for the host. The running counter is 13 bits wide by default, so a valid length runs from 1 to 8191 bytes. A frame of 8192 bytes or more is reported as an overflow, and the latched length is held at the saturated count.

The host reads the frozen status and then issues a receive-acknowledge command. The command releases the status. Bytes that arrive in the meantime are already counted towards the next frame, so no byte is lost while the host is slow.

The block also reports how many bytes of the last partial burst are waiting in the receive FIFO. The FIFO threshold is a selectable power of two, so this residue is the latched length masked by the threshold. When the remainder is zero, the residue is the full threshold.

Top module: `rfl_frame_len`

## Requirements
- R1: After a synchronous active-low reset, `len_o` is 0, `ovf_o` is 0, `vld_o` is 0 and `res_o` is 0.
- R2: An end-of-message strobe latches the frame's byte count. A byte strobe given in the same cycle as the end-of-message strobe belongs to the ending frame. `len_o`, `ovf_o` and `vld_o` show the result from the clock edge after the strobe.
- R3: The running count saturates at 2^LEN_W-1 and does not wrap. A frame of 2^LEN_W bytes or more latches `len_o` = 2^LEN_W-1 and `ovf_o` = 1. A frame of 2^LEN_W-1 bytes or fewer latches `ovf_o` = 0.
- R4: A receive-acknowledge (`rack_i` = 1) with no accepted end-of-message strobe in the same cycle clears `len_o`, `ovf_o` and `vld_o` to 0 at the next edge.
- R5: While `vld_o` = 1, `res_o` = `len_o` mod T, where T = 2^(THR_LOG_MIN + `thr_sel_i`). A zero remainder gives `res_o` = T. While `vld_o` = 0, `res_o` = 0. `res_o` follows `thr_sel_i` without a clock edge.
- R6: A `thr_sel_i` value of THR_NUM or more selects the largest threshold, 2^(THR_LOG_MIN+THR_NUM-1).
- R7: Bytes that arrive after an end-of-message strobe but before the acknowledge leave the latched values unchanged. They count towards the next frame.
- R8: An end-of-message strobe that arrives while `vld_o` = 1 without an acknowledge in the same cycle is not latched. The running count still restarts from zero after it.
- R9: When acknowledge and end-of-message arrive in the same cycle, the old status is released and the new frame is latched.
- R10: While `xp_en_i` = 0, byte and end-of-message strobes have no effect on the count or the status.
- R11: An end-of-message strobe with no counted byte (an empty frame) is not latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xp_en_i | input | 1 | Transparent mode enable |
| byte_stb_i | input | 1 | One received byte accepted this cycle |
| eom_stb_i | input | 1 | End of message this cycle |
| rack_i | input | 1 | Receive-acknowledge command from host |
| thr_sel_i | input | SEL_W | FIFO threshold select (log2 offset from THR_LOG_MIN) |
| len_o | output | LEN_W | Latched frame length |
| ovf_o | output | 1 | Latched length overflow flag |
| res_o | output | THR_LOG_MIN+THR_NUM | Bytes of the last burst waiting in the FIFO |
| vld_o | output | 1 | Latched status valid |

## Verification
The bench builds the block with LEN_W = 7, THR_LOG_MIN = 2 and THR_NUM = 3, which gives thresholds of 4, 8 and 16 and a saturation point of 127 bytes. With these values it can send every frame length from 1 to 130 in both end-of-message placements. For each latched length it checks the residue under all four select codes. The sweep therefore covers every remainder, including the zero-remainder case, the clamped select code and the overflow boundary. Directed sequences then cover the acknowledge interactions, strobes given with transparent mode off, and empty frames.

// File: rtl/rfl_pkg.sv
package rfl_pkg;

  // log2 of the active threshold; out-of-range selects clamp to the last option
  function automatic int unsigned rfl_sel_log(input int unsigned sel,
                                              input int unsigned lg_min,
                                              input int unsigned n_opt);
    int unsigned s;
    s = (sel >= n_opt) ? n_opt - 1 : sel;
    return lg_min + s;
  endfunction

  // bytes of the final burst: length masked by threshold, zero maps to threshold
  function automatic int unsigned rfl_resid(input int unsigned len,
                                            input int unsigned lg);
    int unsigned thr;
    int unsigned rem;
    thr = 32'd1 << lg;
    rem = len & (thr - 1);
    return (rem == 0) ? thr : rem;
  endfunction

endpackage

// File: rtl/rfl_run_cnt.sv
module rfl_run_cnt #(
  parameter int LEN_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  input  logic             restart_i,
  output logic [LEN_W-1:0] tot_o,
  output logic             tot_ovf_o
);
  localparam logic [LEN_W-1:0] CNT_MAX = {LEN_W{1'b1}};

  logic [LEN_W-1:0] cnt_q;
  logic             ovf_q;
  logic             at_max;

  assign at_max    = (cnt_q == CNT_MAX);
  // totals include a byte that arrives in this same cycle
  assign tot_o     = (inc_i && !at_max) ? cnt_q + 1'b1 : cnt_q;
  assign tot_ovf_o = ovf_q | (inc_i & at_max);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (restart_i) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= tot_o;
      ovf_q <= tot_ovf_o;
    end
  end

  a_r3_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (at_max && !restart_i) |=> (cnt_q == CNT_MAX));

  a_r3_ovf_needs_max: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |-> at_max);

endmodule

// File: rtl/rfl_status.sv
module rfl_status #(
  parameter int LEN_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eom_acc_i,
  input  logic             rack_i,
  input  logic [LEN_W-1:0] tot_i,
  input  logic             tot_ovf_i,
  output logic [LEN_W-1:0] len_o,
  output logic             ovf_o,
  output logic             vld_o
);
  localparam logic [LEN_W-1:0] CNT_MAX = {LEN_W{1'b1}};

  logic latch_ev;
  logic clear_ev;

  // the acknowledge releases old status first, so a same-cycle end can latch
  assign latch_ev = eom_acc_i && (tot_i != '0) && (!vld_o || rack_i);
  assign clear_ev = rack_i && !latch_ev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_o <= '0;
      ovf_o <= 1'b0;
      vld_o <= 1'b0;
    end else if (latch_ev) begin
      len_o <= tot_i;
      ovf_o <= tot_ovf_i;
      vld_o <= 1'b1;
    end else if (clear_ev) begin
      len_o <= '0;
      ovf_o <= 1'b0;
      vld_o <= 1'b0;
    end
  end

  a_r4_rack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    clear_ev |=> (!vld_o && !ovf_o && len_o == '0));

  a_r7_hold_until_rack: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_o && !rack_i) |=> (vld_o && $stable(len_o) && $stable(ovf_o)));

  a_r3_ovf_at_max: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |-> (len_o == CNT_MAX));

  a_r11_valid_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o |-> (len_o != '0));

endmodule

// File: rtl/rfl_residue.sv
module rfl_residue #(
  parameter int LEN_W       = 13,
  parameter int THR_LOG_MIN = 4,
  parameter int THR_NUM     = 3,
  parameter int SEL_W       = 2,
  parameter int RES_W       = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LEN_W-1:0] len_i,
  input  logic             vld_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [RES_W-1:0] res_o
);
  import rfl_pkg::*;

  int unsigned lg;
  logic [RES_W-1:0] thr;

  always_comb begin
    lg    = rfl_sel_log(32'(sel_i), THR_LOG_MIN, THR_NUM);
    thr   = RES_W'(32'd1 << lg);
    res_o = vld_i ? RES_W'(rfl_resid(32'(len_i), lg)) : '0;
  end

  a_r5_res_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    vld_i |-> (res_o != '0 && res_o <= thr));

  a_r5_res_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_i |-> (res_o == '0));

endmodule

// File: rtl/rfl_frame_len.sv
module rfl_frame_len #(
  parameter int LEN_W       = 13,
  parameter int THR_LOG_MIN = 4,
  parameter int THR_NUM     = 3,
  parameter int SEL_W       = (THR_NUM > 1) ? $clog2(THR_NUM) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           xp_en_i,
  input  logic                           byte_stb_i,
  input  logic                           eom_stb_i,
  input  logic                           rack_i,
  input  logic [SEL_W-1:0]               thr_sel_i,
  output logic [LEN_W-1:0]               len_o,
  output logic                           ovf_o,
  output logic [THR_LOG_MIN+THR_NUM-1:0] res_o,
  output logic                           vld_o
);
  localparam int RES_W = THR_LOG_MIN + THR_NUM;

  // named internal events for the checks
  logic             byte_acc;
  logic             eom_acc;
  logic [LEN_W-1:0] run_tot;
  logic             run_ovf;

  assign byte_acc = xp_en_i & byte_stb_i;
  assign eom_acc  = xp_en_i & eom_stb_i;

  rfl_run_cnt #(.LEN_W(LEN_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .inc_i     (byte_acc),
    .restart_i (eom_acc),
    .tot_o     (run_tot),
    .tot_ovf_o (run_ovf)
  );

  rfl_status #(.LEN_W(LEN_W)) u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .eom_acc_i (eom_acc),
    .rack_i    (rack_i),
    .tot_i     (run_tot),
    .tot_ovf_i (run_ovf),
    .len_o     (len_o),
    .ovf_o     (ovf_o),
    .vld_o     (vld_o)
  );

  rfl_residue #(
    .LEN_W       (LEN_W),
    .THR_LOG_MIN (THR_LOG_MIN),
    .THR_NUM     (THR_NUM),
    .SEL_W       (SEL_W),
    .RES_W       (RES_W)
  ) u_res (
    .clk   (clk),
    .rst_n (rst_n),
    .len_i (len_o),
    .vld_i (vld_o),
    .sel_i (thr_sel_i),
    .res_o (res_o)
  );

  a_r10_idle_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (!xp_en_i && !rack_i) |=> ($stable(vld_o) && $stable(len_o)));

  a_r2_latch_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (eom_acc && !vld_o && run_tot != '0) |=> vld_o);

endmodule

// File: tb/test_rfl_frame_len.sv
`timescale 1ns/1ps
module test_rfl_frame_len;
  localparam int LEN_W = 7;
  localparam int LGMIN = 2;
  localparam int NOPT  = 3;
  localparam int SEL_W = 2;
  localparam int RES_W = LGMIN + NOPT;
  localparam int MAXC  = (1 << LEN_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, bs = 1'b0, eo = 1'b0, rk = 1'b0;
  logic [SEL_W-1:0] sel = '0;
  logic [LEN_W-1:0] len;
  logic ovf, vld;
  logic [RES_W-1:0] res;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  rfl_frame_len #(.LEN_W(LEN_W), .THR_LOG_MIN(LGMIN), .THR_NUM(NOPT)) i_rfl_frame_len (
    .clk(clk), .rst_n(rst_n), .xp_en_i(en), .byte_stb_i(bs), .eom_stb_i(eo),
    .rack_i(rk), .thr_sel_i(sel), .len_o(len), .ovf_o(ovf), .res_o(res), .vld_o(vld)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_res(input int l, input int s);
    int lg;
    int t;
    lg = LGMIN + ((s >= NOPT) ? NOPT - 1 : s);
    t  = 1 << lg;
    return (l % t == 0) ? t : l % t;
  endfunction

  // n bytes; eom on the last byte (eom_last) or one cycle after; rack on the eom cycle
  task automatic send(input int n, input bit mode, input bit eom_last, input bit rk_eom);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      en = mode; bs = 1'b1; eo = (eom_last && i == n - 1); rk = (eo && rk_eom);
    end
    if (!eom_last || n == 0) begin
      @(negedge clk);
      en = mode; bs = 1'b0; eo = 1'b1; rk = rk_eom;
    end
    @(negedge clk);
    bs = 1'b0; eo = 1'b0; rk = 1'b0; en = 1'b1;
  endtask

  task automatic ack;
    @(negedge clk); rk = 1'b1;
    @(negedge clk); rk = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog all requirements act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 len", int'(len), 0); chk("R1 ovf", int'(ovf), 0);
    chk("R1 vld", int'(vld), 0); chk("R1 res", int'(res), 0);
    rst_n = 1'b1; en = 1'b1;

    // R2 R3 R5 R6 sweep
    for (int n = 1; n <= MAXC + 3; n++) begin
      for (int pl = 0; pl < 2; pl++) begin
        int el;
        send(n, 1'b1, pl[0], 1'b0);
        el = (n > MAXC) ? MAXC : n;
        chk("R2 valid", int'(vld), 1);
        chk("R2/R3 len", int'(len), el);
        chk("R3 ovf", int'(ovf), (n > MAXC) ? 1 : 0);
        for (int s = 0; s < 4; s++) begin
          sel = SEL_W'(s); #0.5;
          chk(s >= NOPT ? "R6 clamp residue" : "R5 residue", int'(res), exp_res(el, s));
        end
        sel = '0;
        ack;
        chk("R4 vld", int'(vld), 0); chk("R4 len", int'(len), 0);
        chk("R4 ovf", int'(ovf), 0); chk("R5 res idle", int'(res), 0);
      end
    end

    // R7 bytes before ack go into next frame
    send(10, 1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 5; i++) begin @(negedge clk); bs = 1'b1; end
    @(negedge clk); bs = 1'b0;
    chk("R7 hold len", int'(len), 10); chk("R7 hold vld", int'(vld), 1);
    ack;
    send(3, 1'b1, 1'b1, 1'b0);
    chk("R7 next frame len", int'(len), 8);
    ack;

    // R8 eom while valid is dropped, counter restarts
    send(6, 1'b1, 1'b1, 1'b0);
    send(9, 1'b1, 1'b1, 1'b0);
    chk("R8 old len kept", int'(len), 6);
    ack;
    send(2, 1'b1, 1'b1, 1'b0);
    chk("R8 restart len", int'(len), 2);

    // R9 rack with eom in same cycle
    send(11, 1'b1, 1'b1, 1'b1);
    chk("R9 new len", int'(len), 11); chk("R9 vld", int'(vld), 1);
    ack;

    // R10 mode off ignores strobes
    send(20, 1'b0, 1'b1, 1'b0);
    chk("R10 vld", int'(vld), 0); chk("R10 len", int'(len), 0);
    send(4, 1'b1, 1'b1, 1'b0);
    chk("R10 later count", int'(len), 4);
    ack;

    // R11 empty frame
    send(0, 1'b1, 1'b0, 1'b0);
    chk("R11 empty vld", int'(vld), 0); chk("R11 empty len", int'(len), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule